// File: doc/BRIEF.md
# Grouped Power-Rail Sequencer with Retry

This block brings a set of supply rails up and down in a controlled order. Each rail belongs to a power group, fixed by a parameter. All rails of one group share one enable output and one discharge output. A group counts as good only when every one of its rails reports power good. When the master enable is raised, groups are switched on from the lowest group number to the highest. A group is enabled only after the group below it is good and a programmable gap has elapsed. Every group must report good within a qualification window after its enable, or the attempt fails.

Several events stop the rails: a failed qualification, the loss of any rail's power good once everything is up, an external fault input, or the master enable going low. The block then switches groups off from the highest group to the lowest, asserting each group's discharge output. It moves to the next lower group only after every rail of the current group has gone low. The first three events are faults and pull the active-low fault output low. What follows depends on a fault policy input: ignore, shut down and hold, a limited number of retries, or retry forever. A retry waits until every power-good input is low, then runs a restart timer, then starts a new power-up.

Top module: `rail_stager`

## Requirements
- R1: While reset is high and in the first cycle after it, every group enable is low, every group discharge is high, and fault_n is high.
- R2: A group's combined power good is the AND of its member rails. The default map is rails 0, 2 and 3 in group 0, rail 1 in group 1, and rails 4 and 5 in group 2. A group's enable and discharge are never high together.
- R3: Groups power up in ascending order. The enable of group g+1 rises SEQ_DLY+1 cycles after the first cycle in which group g's combined power good is high, so SEQ_DLY = 0 gives the next cycle.
- R4: If a group's combined power good is still low QUAL_WIN cycles after its enable rises, fault_n falls exactly QUAL_WIN cycles after that enable rise (policy other than ignore), and a shutdown follows.
- R5: With all groups up, the loss of any rail's power good makes fault_n fall one cycle after the first cycle of the loss, and a shutdown follows.
- R6: Shutdown drops enables from the highest enabled group to the lowest. Each dropped group's discharge rises with its enable fall. The next lower enable falls one cycle after the first cycle in which no rail of the current group is good. Discharge stays high until that group's enable rises again.
- R7: ext_fault high forces a shutdown with fault_n low under every policy. No enable rises in the cycle after a cycle with ext_fault high. A retry does not start while ext_fault stays high.
- R8: enable low shuts the rails down without a fault: fault_n stays high, and no enable rises in the cycle after a cycle with enable low.
- R9: On a retry, group 0's enable rises RESTART_DLY+2 cycles after the first cycle in which all power-good inputs are low, and fault_n rises in that same cycle.
- R10: fault_mode encoding: 0 = ignore, where a qualification timeout counts as success and the loss of power good once all groups are up is not acted on. 1 = shut down and hold. 2 = retry up to retry_limit times, where values above 6 count as 6. 3 = retry forever. Under modes 0 and 1, an external fault is held without retry.
- R11: A held fault keeps fault_n low until enable goes low, or until retry_limit is raised above the retries already used in mode 2, which starts another attempt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Master enable; high requests power-up |
| ext_fault | input | 1 | External input fault, forces power-down |
| rail_pg | input | NRAILS | Per-rail power-good inputs |
| fault_mode | input | 2 | Fault policy (R10 encoding) |
| retry_limit | input | 3 | Number of retries for mode 2 |
| grp_en | output | NGROUPS | Per-group regulator enable |
| grp_dchg | output | NGROUPS | Per-group discharge control |
| fault_n | output | 1 | Active-low fault indication |

## Verification
The hardest situation to reach is the held-fault state after the retry budget runs out, and then leaving it by raising the limit. The bench models every rail as a regulator whose power good follows its group enable with a ramp and a fall delay. It can hold a chosen rail stuck low. Holding a group-1 rail low makes every attempt end in a qualification timeout. The bench counts group-0 enable rises until the block holds the fault. It then raises retry_limit, including to a value above 6, and counts the extra attempts each change produces.

// File: rtl/rail_stager_pkg.sv
package rail_stager_pkg;

    localparam int MAX_RETRIES = 6;

    typedef enum logic [2:0] {
        ST_IDLE, ST_QUAL, ST_GAP, ST_ON, ST_DOWN, ST_WAITLOW, ST_RESTART, ST_LOCK
    } stage_e;

    typedef enum logic [1:0] {
        POL_IGNORE   = 2'd0,
        POL_SHUTDOWN = 2'd1,
        POL_LIMITED  = 2'd2,
        POL_FOREVER  = 2'd3
    } policy_e;

    // Decide whether another power-up attempt is allowed.
    function automatic logic may_retry(policy_e pol, logic [2:0] used, logic [2:0] limit);
        logic [2:0] lim;
        lim = (int'(limit) > MAX_RETRIES) ? 3'(MAX_RETRIES) : limit;
        return (pol == POL_FOREVER) || ((pol == POL_LIMITED) && (used < lim));
    endfunction

endpackage

// File: rtl/rs_group_combine.sv
module rs_group_combine #(
    parameter int NRAILS  = 6,
    parameter int NGROUPS = 3,
    parameter int RAIL_GROUP [NRAILS] = '{0, 1, 0, 0, 2, 2}
) (
    input  logic [NRAILS-1:0]  rail_pg,
    output logic [NGROUPS-1:0] grp_all,
    output logic [NGROUPS-1:0] grp_any
);
    function automatic logic [NRAILS-1:0] member_mask(int g);
        logic [NRAILS-1:0] m;
        m = '0;
        for (int r = 0; r < NRAILS; r++)
            if (RAIL_GROUP[r] == g) m[r] = 1'b1;
        return m;
    endfunction

    for (genvar g = 0; g < NGROUPS; g++) begin : g_grp
        localparam logic [NRAILS-1:0] MASK = member_mask(g);
        assign grp_all[g] = &(rail_pg | ~MASK);
        assign grp_any[g] = |(rail_pg & MASK);
    end
endmodule

// File: rtl/rs_timer.sv
module rs_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    output logic [TW-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || clr)        cnt <= '0;
        else if (cnt != '1)    cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/rs_retry_ctrl.sv
module rs_retry_ctrl
    import rail_stager_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       inc,
    input  logic [1:0] mode,
    input  logic [2:0] limit,
    output logic       allow
);
    logic [2:0] used;

    always_ff @(posedge clk) begin
        if (rst || clr)               used <= '0;
        else if (inc && used != '1)   used <= used + 1'b1;
    end

    assign allow = may_retry(policy_e'(mode), used, limit);
endmodule

// File: rtl/rail_stager.sv
module rail_stager
    import rail_stager_pkg::*;
#(
    parameter int NRAILS      = 6,
    parameter int NGROUPS     = 3,
    parameter int RAIL_GROUP [NRAILS] = '{0, 1, 0, 0, 2, 2},
    parameter int TW          = 16,
    parameter int SEQ_DLY     = 4,
    parameter int QUAL_WIN    = 20,
    parameter int RESTART_DLY = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               enable,
    input  logic               ext_fault,
    input  logic [NRAILS-1:0]  rail_pg,
    input  logic [1:0]         fault_mode,
    input  logic [2:0]         retry_limit,
    output logic [NGROUPS-1:0] grp_en,
    output logic [NGROUPS-1:0] grp_dchg,
    output logic               fault_n
);
    localparam int IW = (NGROUPS > 1) ? $clog2(NGROUPS) : 1;
    localparam logic [IW-1:0] LAST     = IW'(NGROUPS - 1);
    localparam logic [TW-1:0] GAP_END  = TW'((SEQ_DLY > 0) ? SEQ_DLY - 1 : 0);
    localparam logic [TW-1:0] QUAL_END = TW'((QUAL_WIN > 0) ? QUAL_WIN - 1 : 0);
    localparam logic [TW-1:0] RST_END  = TW'((RESTART_DLY > 0) ? RESTART_DLY - 1 : 0);

    stage_e              st, st_n;
    logic [IW-1:0]       idx, idx_n, nxt;
    logic [NGROUPS-1:0]  en_n, dchg_n, grp_all, grp_any;
    logic                fault_q, flt_n, go_down, tmr_clr, r_inc, r_clr, allow;
    logic [TW-1:0]       cnt;
    policy_e             pol;

    assign pol = policy_e'(fault_mode);
    assign nxt = idx + 1'b1;

    rs_group_combine #(.NRAILS(NRAILS), .NGROUPS(NGROUPS), .RAIL_GROUP(RAIL_GROUP)) u_comb (
        .rail_pg(rail_pg), .grp_all(grp_all), .grp_any(grp_any));

    rs_timer #(.TW(TW)) u_tmr (.clk(clk), .rst(rst), .clr(tmr_clr), .cnt(cnt));

    rs_retry_ctrl u_retry (.clk(clk), .rst(rst), .clr(r_clr), .inc(r_inc),
        .mode(fault_mode), .limit(retry_limit), .allow(allow));

    always_comb begin
        st_n = st; idx_n = idx; en_n = grp_en; dchg_n = grp_dchg;
        flt_n = fault_q; go_down = 1'b0; r_inc = 1'b0; r_clr = 1'b0;
        case (st)
            ST_IDLE: begin
                r_clr = 1'b1;
                flt_n = 1'b0;
                if (enable && !ext_fault) begin
                    st_n = ST_QUAL; idx_n = '0; en_n[0] = 1'b1; dchg_n[0] = 1'b0;
                end
            end
            ST_QUAL, ST_GAP, ST_ON: begin
                if (ext_fault) begin
                    go_down = 1'b1; flt_n = 1'b1;
                end else if (!enable) begin
                    go_down = 1'b1;
                end else if (st == ST_QUAL) begin
                    if (grp_all[idx] || (cnt == QUAL_END && pol == POL_IGNORE)) begin
                        if (idx == LAST)       st_n = ST_ON;
                        else if (SEQ_DLY == 0) begin
                            idx_n = nxt; en_n[nxt] = 1'b1; dchg_n[nxt] = 1'b0;
                        end else               st_n = ST_GAP;
                    end else if (cnt == QUAL_END) begin
                        go_down = 1'b1; flt_n = 1'b1;
                    end
                end else if (st == ST_GAP) begin
                    if (cnt == GAP_END) begin
                        st_n = ST_QUAL; idx_n = nxt; en_n[nxt] = 1'b1; dchg_n[nxt] = 1'b0;
                    end
                end else if (!(&grp_all) && pol != POL_IGNORE) begin
                    go_down = 1'b1; flt_n = 1'b1;
                end
            end
            ST_DOWN: begin
                if (!grp_any[idx]) begin
                    if (idx != '0) begin
                        idx_n = idx - 1'b1; en_n[idx - 1'b1] = 1'b0; dchg_n[idx - 1'b1] = 1'b1;
                    end else if (!enable) begin
                        st_n = ST_IDLE; flt_n = 1'b0;
                    end else if (fault_q) begin
                        st_n = allow ? ST_WAITLOW : ST_LOCK;
                    end else begin
                        st_n = ST_IDLE;
                    end
                end
            end
            ST_WAITLOW: begin
                if (!enable) begin
                    st_n = ST_IDLE; flt_n = 1'b0;
                end else if (rail_pg == '0 && !ext_fault) st_n = ST_RESTART;
            end
            ST_RESTART: begin
                if (!enable) begin
                    st_n = ST_IDLE; flt_n = 1'b0;
                end else if (ext_fault) st_n = ST_WAITLOW;
                else if (cnt == RST_END) begin
                    st_n = ST_QUAL; idx_n = '0; en_n[0] = 1'b1; dchg_n[0] = 1'b0;
                    flt_n = 1'b0; r_inc = 1'b1;
                end
            end
            ST_LOCK: begin
                if (!enable) begin
                    st_n = ST_IDLE; flt_n = 1'b0;
                end else if (allow) st_n = ST_WAITLOW;
            end
            default: st_n = ST_IDLE;
        endcase
        if (go_down) begin
            st_n = ST_DOWN; en_n[idx] = 1'b0; dchg_n[idx] = 1'b1;
        end
    end

    assign tmr_clr = (st_n != st) || (idx_n != idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_IDLE; idx <= '0; grp_en <= '0; grp_dchg <= '1; fault_q <= 1'b0;
        end else begin
            st <= st_n; idx <= idx_n; grp_en <= en_n; grp_dchg <= dchg_n; fault_q <= flt_n;
        end
    end

    assign fault_n = ~fault_q;
endmodule

// File: rtl/rail_stager_chk.sv
module rail_stager_chk #(
    parameter int NGROUPS = 3
) (
    input logic               clk,
    input logic               rst,
    input logic               enable,
    input logic               ext_fault,
    input logic [NGROUPS-1:0] grp_en,
    input logic [NGROUPS-1:0] grp_dchg,
    input logic               fault_n
);
    for (genvar g = 0; g < NGROUPS; g++) begin : g_chk
        // R2: enable and discharge of one group are exclusive
        a_r2_en_dchg_excl: assert property (@(posedge clk) disable iff (rst)
            !(grp_en[g] && grp_dchg[g]));
        if (g > 0) begin : g_up
            // R3: a group turns on only while the group below is on
            a_r3_ascending: assert property (@(posedge clk) disable iff (rst)
                $rose(grp_en[g]) |-> grp_en[g-1]);
        end
        if (g < NGROUPS - 1) begin : g_dn
            // R6: a group turns off only once the group above is off
            a_r6_reverse_off: assert property (@(posedge clk) disable iff (rst)
                $fell(grp_en[g]) |-> !grp_en[g+1]);
        end
    end

    // R7: external fault blocks any enable rise in the next cycle
    a_r7_ext_blocks: assert property (@(posedge clk) disable iff (rst)
        ext_fault |=> ((grp_en & ~$past(grp_en)) == '0));

    // R8: master enable low blocks any enable rise in the next cycle
    a_r8_disable_blocks: assert property (@(posedge clk) disable iff (rst)
        !enable |=> ((grp_en & ~$past(grp_en)) == '0));

    // R11: fault_n clears only with a new attempt or after enable low
    a_r11_fault_release: assert property (@(posedge clk) disable iff (rst)
        $rose(fault_n) |-> ($rose(grp_en[0]) || !$past(enable)));
endmodule

bind rail_stager rail_stager_chk #(.NGROUPS(NGROUPS)) u_chk (
    .clk(clk), .rst(rst), .enable(enable), .ext_fault(ext_fault),
    .grp_en(grp_en), .grp_dchg(grp_dchg), .fault_n(fault_n));

// File: tb/sim_rail_stager.sv
`timescale 1ns/1ps
module sim_rail_stager;
    localparam int NR = 6, NG = 3;
    localparam int SEQ_DLY = 4, QUAL_WIN = 20, RESTART_DLY = 8;
    localparam int RAMP = 3, FALL = 2;
    localparam int GMAP [NR] = '{0, 1, 0, 0, 2, 2};

    logic clk = 1'b0, rst = 1'b1, enable = 1'b0, ext_fault = 1'b0;
    logic [NR-1:0] rail_pg = '0;
    logic [1:0] fault_mode = 2'd2;
    logic [2:0] retry_limit = 3'd2;
    logic [NG-1:0] grp_en, grp_dchg;
    logic fault_n;

    always #2.5 clk = ~clk;

    rail_stager u0 (.clk(clk), .rst(rst), .enable(enable), .ext_fault(ext_fault),
        .rail_pg(rail_pg), .fault_mode(fault_mode), .retry_limit(retry_limit),
        .grp_en(grp_en), .grp_dchg(grp_dchg), .fault_n(fault_n));

    int n_chk = 0, n_err = 0;
    bit done = 0;
    bit stuck [NR];
    int slow [NR];

    // Regulator model: power good follows group enable with ramp / fall delays
    int up_c [NR], dn_c [NR];
    initial begin
        for (int r = 0; r < NR; r++) begin stuck[r] = 0; slow[r] = 0; up_c[r] = 0; dn_c[r] = 0; end
        forever begin
            @(posedge clk); #1;
            for (int r = 0; r < NR; r++) begin
                if (grp_en[GMAP[r]] && !stuck[r]) begin
                    dn_c[r] = 0;
                    if (up_c[r] < RAMP + slow[r]) up_c[r]++;
                    rail_pg[r] = (up_c[r] >= RAMP + slow[r]);
                end else begin
                    up_c[r] = 0;
                    if (stuck[r]) rail_pg[r] = 1'b0;
                    else if (rail_pg[r]) begin
                        dn_c[r]++;
                        if (dn_c[r] >= FALL) begin rail_pg[r] = 1'b0; dn_c[r] = 0; end
                    end
                end
            end
        end
    end

    // Event monitor, sampled at the falling edge
    int cyc = 0, en0_rises = 0, fn_falls = 0;
    int t_en_rise [NG], t_en_fall [NG], t_gpg_rise [NG], t_gpg_fall [NG], t_gany_fall [NG];
    int t_rail_rise [NR];
    int t_fn_fall = 0, t_fn_rise = 0, t_all_low = 0;
    logic [NG-1:0] p_en = '0, p_gpg = '0, p_gany = '0;
    logic [NR-1:0] p_pg = '0;
    logic p_fn = 1'b1;
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            begin
                logic [NG-1:0] gpg, gany;
                gpg = '1; gany = '0;
                for (int r = 0; r < NR; r++) begin
                    if (!rail_pg[r]) gpg[GMAP[r]] = 1'b0;
                    if (rail_pg[r]) gany[GMAP[r]] = 1'b1;
                    if (rail_pg[r] && !p_pg[r]) t_rail_rise[r] = cyc;
                end
                for (int g = 0; g < NG; g++) begin
                    if (grp_en[g] && !p_en[g]) begin t_en_rise[g] = cyc; if (g == 0) en0_rises++; end
                    if (!grp_en[g] && p_en[g]) t_en_fall[g] = cyc;
                    if (gpg[g] && !p_gpg[g]) t_gpg_rise[g] = cyc;
                    if (!gpg[g] && p_gpg[g]) t_gpg_fall[g] = cyc;
                    if (!gany[g] && p_gany[g]) t_gany_fall[g] = cyc;
                end
                if (rail_pg == '0 && p_pg != '0) t_all_low = cyc;
                if (!fault_n && p_fn) begin t_fn_fall = cyc; fn_falls++; end
                if (fault_n && !p_fn) t_fn_rise = cyc;
                p_en = grp_en; p_gpg = gpg; p_gany = gany; p_pg = rail_pg; p_fn = fault_n;
            end
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
        #0.2;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
            $finish;
        end
    endtask

    task automatic go_idle();
        enable = 1'b0; ext_fault = 1'b0;
        for (int r = 0; r < NR; r++) begin stuck[r] = 0; slow[r] = 0; end
        wait_cyc(80);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        wait_cyc(4);
        chk("R1 en during reset", int'(grp_en), 0);
        chk("R1 dchg during reset", int'(grp_dchg), 7);
        rst = 1'b0;
        wait_cyc(1);
        chk("R1 en after reset", int'(grp_en), 0);
        chk("R1 dchg after reset", int'(grp_dchg), 7);
        chk("R1 fault_n after reset", int'(fault_n), 1);
    endtask

    task automatic t_powerup();
        fault_mode = 2'd2; retry_limit = 3'd2;
        slow[3] = 6;
        enable = 1'b1;
        wait_cyc(100);
        chk("R3 all enabled", int'(grp_en), 7);
        chk("R2 dchg low when up", int'(grp_dchg), 0);
        chk("R3 no fault", int'(fault_n), 1);
        chk("R2 group0 AND waits slow rail3", t_en_rise[1] - t_rail_rise[3], SEQ_DLY + 1);
        chk("R3 gap g0->g1", t_en_rise[1] - t_gpg_rise[0], SEQ_DLY + 1);
        chk("R3 gap g1->g2", t_en_rise[2] - t_gpg_rise[1], SEQ_DLY + 1);
        chk("R3 order", int'(t_en_rise[0] < t_en_rise[1] && t_en_rise[1] < t_en_rise[2]), 1);
    endtask

    task automatic t_disable();
        int f0;
        f0 = fn_falls;
        enable = 1'b0;
        wait_cyc(60);
        chk("R8 all off", int'(grp_en), 0);
        chk("R6 dchg held", int'(grp_dchg), 7);
        chk("R8 no fault on disable", fn_falls - f0, 0);
        chk("R6 g1 off after g2 rails low", t_en_fall[1] - t_gany_fall[2], 1);
        chk("R6 g0 off after g1 rails low", t_en_fall[0] - t_gany_fall[1], 1);
        chk("R6 reverse order", int'(t_en_fall[2] < t_en_fall[1] && t_en_fall[1] < t_en_fall[0]), 1);
    endtask

    task automatic t_pgloss();
        fault_mode = 2'd2; retry_limit = 3'd2;
        enable = 1'b1;
        wait_cyc(80);
        stuck[4] = 1;
        wait_cyc(3);
        stuck[4] = 0;
        chk("R5 fault on pg loss", t_fn_fall - t_gpg_fall[2], 1);
        wait_cyc(120);
        chk("R9 restart delay", t_en_rise[0] - t_all_low, RESTART_DLY + 2);
        chk("R9 fault_n clears at restart", t_fn_rise, t_en_rise[0]);
        chk("R9 up again", int'(grp_en), 7);
        chk("R9 fault_n high", int'(fault_n), 1);
    endtask

    task automatic t_qual_retry();
        int e0;
        fault_mode = 2'd2; retry_limit = 3'd2;
        stuck[1] = 1;
        e0 = en0_rises;
        enable = 1'b1;
        wait_cyc(40);
        chk("R4 qual timeout", t_fn_fall - t_en_rise[1], QUAL_WIN);
        wait_cyc(400);
        chk("R10 limited attempts", en0_rises - e0, 3);
        chk("R11 held fault", int'(fault_n), 0);
        chk("R6 held off with dchg", int'(grp_dchg), 7);
        retry_limit = 3'd3;
        wait_cyc(300);
        chk("R11 raised limit one more", en0_rises - e0, 4);
        chk("R11 held again", int'(fault_n), 0);
        retry_limit = 3'd7;
        wait_cyc(500);
        chk("R10 limit above 6 clamps", en0_rises - e0, 7);
        enable = 1'b0;
        wait_cyc(2);
        chk("R11 enable low releases", int'(fault_n), 1);
        go_idle();
    endtask

    task automatic t_ext();
        int e0;
        fault_mode = 2'd2; retry_limit = 3'd2;
        enable = 1'b1;
        wait_cyc(80);
        ext_fault = 1'b1;
        wait_cyc(1);
        chk("R7 fault_n falls", int'(fault_n), 0);
        e0 = en0_rises;
        wait_cyc(80);
        chk("R7 all off", int'(grp_en), 0);
        chk("R7 no restart while ext high", en0_rises - e0, 0);
        ext_fault = 1'b0;
        wait_cyc(100);
        chk("R7 restart after release", en0_rises - e0, 1);
        chk("R7 up again", int'(grp_en), 7);
        go_idle();
    endtask

    task automatic t_ignore();
        int f0;
        fault_mode = 2'd0;
        stuck[1] = 1;
        f0 = fn_falls;
        enable = 1'b1;
        wait_cyc(120);
        chk("R10 ignore passes timeout", int'(grp_en), 7);
        stuck[4] = 1;
        wait_cyc(30);
        chk("R10 ignore pg loss", int'(grp_en), 7);
        chk("R10 ignore no fault", fn_falls - f0, 0);
        go_idle();
    endtask

    task automatic t_hold();
        int e0;
        fault_mode = 2'd1;
        enable = 1'b1;
        wait_cyc(80);
        e0 = en0_rises;
        stuck[5] = 1;
        wait_cyc(200);
        chk("R10 mode1 held fault", int'(fault_n), 0);
        chk("R10 mode1 no retry", en0_rises - e0, 0);
        chk("R10 mode1 all off", int'(grp_en), 0);
        go_idle();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        t_reset();
        t_powerup();
        t_disable();
        go_idle();
        t_pgloss();
        go_idle();
        t_qual_retry();
        t_ext();
        t_ignore();
        t_hold();
        finish_run();
    end
endmodule